// File: doc/BRIEF.md
# Unified Data-Space Access Unit

This unit presents a single flat, byte-addressed data space and routes each load or store to one of four storage targets. These are the general-purpose register file, a bank of standard I/O registers, a bank of extended I/O registers and an internal SRAM. Each target is reached at its own local offset. The register file is itself part of the data space, so a general-purpose register can be read or written with an ordinary data-space address.

A request names its address in one of two ways. It can give the address directly, or it can name one of three 16-bit pointers, each made from a pair of general-purpose registers. Every request takes two cycles. In the first cycle the unit reports busy, reads the pointer pair when one is named, and forms and decodes the effective address. In the second cycle the storage is read or written and `done` is pulsed. A new request is taken in any cycle in which the unit is not busy, including the cycle in which `done` is high. Addresses past the end of the decoded space are flagged, and they neither read nor write anything.

Top module: `dsu_top`

## Requirements
- R1: Effective addresses 0 to 31 access general-purpose register n, where n is the address.
- R2: Effective addresses 32 to 95 access the standard I/O bank at local offset address-32, which is separate storage from every other target.
- R3: Effective addresses 96 to 255 access the extended I/O bank at local offset address-96.
- R4: Effective addresses 256 to 1279 access SRAM at local offset address-256.
- R5: When `reqIndirect` is 1, the effective address is a pointer word built from two registers. `ptrSel` 0 selects registers 27:26, 1 selects 29:28 and 2 selects 31:30, with the low byte in the even register. The value 3 behaves as 2, and `reqAddr` is ignored.
- R6: An effective address of 1280 or above raises `outOfRange` in the done cycle and returns 0x00 on `rdData`. As a write, it changes no storage location.
- R7: A request is accepted on a rising edge where `reqValid` is 1 and `busy` is 0. `busy` is 1 for exactly the following cycle. `done` is 1 for the cycle after that, with `busy` 0, and `rdData` holds the read value during that cycle.
- R8: A request presented while `busy` is 1 is dropped. It is not queued and has no effect.
- R9: The pointer is read in the busy cycle. A request issued in the done cycle of a write to a pointer register therefore sees the new register value.
- R10: A write reports 0x00 on `rdData` in its done cycle, and a later read of the same address returns the written byte.
- R11: After reset, `busy`, `done`, `outOfRange` and `rdData` are 0, and every register-file and I/O location reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqIndirect | input | 1 | 1 = address taken from a pointer pair |
| ptrSel | input | 2 | Pointer select for indirect requests (0, 1, 2; 3 acts as 2) |
| reqAddr | input | 16 | Direct data-space address |
| wrData | input | 8 | Store data |
| rdData | output | 8 | Load result, valid while `done` is 1 |
| busy | output | 1 | Address-compute cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| outOfRange | output | 1 | Effective address beyond the decoded space, valid with `done` |

## Verification
A sequencing state that slips by even one cycle shows up at once as `busy` or `done` on the wrong edge. Because the reference model is compared on every clock, such an error is caught within one cycle of the fault. A decoder that picks the wrong target or offset leaves the written location untouched and changes a different one. That error only reaches the ports when the changed location is read back, so the stimulus follows each write with reads of that address and of the neighbouring region boundaries. A pointer that forms a wrong word, or that is sampled a cycle late, shows up in the done cycle of the very next indirect request as wrong data or a wrong `outOfRange`.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

  typedef enum logic [1:0] {
    TGT_GPR   = 2'd0,
    TGT_STDIO = 2'd1,
    TGT_EXTIO = 2'd2,
    TGT_SRAM  = 2'd3
  } tgtE;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the incoming request
    logic commit;   // address-compute cycle; storage acts at its closing edge
  } ctrlStrobeT;

endpackage

// File: rtl/dsu_ctrl.sv
module dsu_ctrl
  import dsu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output ctrlStrobeT strobe,
  output logic       busy,
  output logic       done
);

  logic addrPhase;
  logic donePhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrPhase <= 1'b0;
      donePhase <= 1'b0;
    end else begin
      addrPhase <= reqValid && !addrPhase;
      donePhase <= addrPhase;
    end
  end

  always_comb begin
    strobe.capture = reqValid && !addrPhase;
    strobe.commit  = addrPhase;
  end

  assign busy = addrPhase;
  assign done = donePhase;

  // R7: busy lasts exactly one cycle
  a_r7_busy_single: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R7: done follows busy
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> done);

  // R7: done never overlaps busy
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R8: a request seen while idle is taken, one seen while busy is not
  a_r8_accept_idle: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

endmodule

// File: rtl/dsu_datapath.sv
module dsu_datapath
  import dsu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int GPR_N   = 32,
  parameter int STDIO_N = 64,
  parameter int EXTIO_N = 160,
  parameter int SRAM_N  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic              reqWrite,
  input  logic              reqIndirect,
  input  logic [1:0]        ptrSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              outOfRange
);

  localparam int GPR_IW  = $clog2(GPR_N);
  localparam int STD_IW  = $clog2(STDIO_N);
  localparam int EXT_IW  = $clog2(EXTIO_N);
  localparam int SRAM_IW = $clog2(SRAM_N);
  localparam logic [ADDR_W-1:0] STD_BASE  = ADDR_W'(GPR_N);
  localparam logic [ADDR_W-1:0] EXT_BASE  = ADDR_W'(GPR_N + STDIO_N);
  localparam logic [ADDR_W-1:0] SRAM_BASE = ADDR_W'(GPR_N + STDIO_N + EXTIO_N);
  localparam logic [ADDR_W-1:0] SPACE_END = ADDR_W'(GPR_N + STDIO_N + EXTIO_N + SRAM_N);
  localparam int PTR_LO_BASE = GPR_N - 6;

  // storage
  logic [DATA_W-1:0] gprMem  [GPR_N];
  logic [DATA_W-1:0] stdMem  [STDIO_N];
  logic [DATA_W-1:0] extMem  [EXTIO_N];
  logic [DATA_W-1:0] sramMem [SRAM_N];

  // captured request
  logic              wrQ, indQ;
  logic [1:0]        selQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrQ   <= 1'b0;
      indQ  <= 1'b0;
      selQ  <= '0;
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobe.capture) begin
      wrQ   <= reqWrite;
      indQ  <= reqIndirect;
      selQ  <= ptrSel;
      addrQ <= reqAddr;
      dataQ <= wrData;
    end
  end

  // pointer pair read and effective address
  logic [1:0]        selEff;
  logic [GPR_IW-1:0] ptrLoIdx, ptrHiIdx;
  logic [ADDR_W-1:0] effAddr;

  always_comb begin
    selEff   = (selQ == 2'd3) ? 2'd2 : selQ;
    ptrLoIdx = GPR_IW'(PTR_LO_BASE + 2 * int'(selEff));
    ptrHiIdx = ptrLoIdx + GPR_IW'(1);
    effAddr  = indQ ? ADDR_W'({gprMem[ptrHiIdx], gprMem[ptrLoIdx]}) : addrQ;
  end

  // region decode
  tgtE                tgt;
  logic               inRange;
  logic [GPR_IW-1:0]  gprIdx;
  logic [STD_IW-1:0]  stdIdx;
  logic [EXT_IW-1:0]  extIdx;
  logic [SRAM_IW-1:0] sramIdx;
  logic [DATA_W-1:0]  rdVal;

  always_comb begin
    inRange = 1'b1;
    tgt     = TGT_GPR;
    if (effAddr < STD_BASE)       tgt = TGT_GPR;
    else if (effAddr < EXT_BASE)  tgt = TGT_STDIO;
    else if (effAddr < SRAM_BASE) tgt = TGT_EXTIO;
    else if (effAddr < SPACE_END) tgt = TGT_SRAM;
    else                          inRange = 1'b0;
    gprIdx  = GPR_IW'(effAddr);
    stdIdx  = STD_IW'(effAddr - STD_BASE);
    extIdx  = EXT_IW'(effAddr - EXT_BASE);
    sramIdx = SRAM_IW'(effAddr - SRAM_BASE);
    unique case (tgt)
      TGT_GPR:   rdVal = gprMem[gprIdx];
      TGT_STDIO: rdVal = stdMem[stdIdx];
      TGT_EXTIO: rdVal = extMem[extIdx];
      default:   rdVal = sramMem[sramIdx];
    endcase
  end

  logic doWrite;
  assign doWrite = strobe.commit && wrQ && inRange;

  // register-file and I/O banks, cleared on reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < GPR_N; i++)   gprMem[i] <= '0;
      for (int i = 0; i < STDIO_N; i++) stdMem[i] <= '0;
      for (int i = 0; i < EXTIO_N; i++) extMem[i] <= '0;
    end else if (doWrite) begin
      if (tgt == TGT_GPR)   gprMem[gprIdx] <= dataQ;
      if (tgt == TGT_STDIO) stdMem[stdIdx] <= dataQ;
      if (tgt == TGT_EXTIO) extMem[extIdx] <= dataQ;
    end
  end

  // SRAM carries no reset
  always_ff @(posedge clk) begin
    if (doWrite && tgt == TGT_SRAM) sramMem[sramIdx] <= dataQ;
  end

  // result registers
  logic [DATA_W-1:0] rdDataQ;
  logic              oorQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ <= '0;
      oorQ    <= 1'b0;
    end else if (strobe.commit) begin
      rdDataQ <= (!wrQ && inRange) ? rdVal : '0;
      oorQ    <= !inRange;
    end
  end

  assign rdData     = rdDataQ;
  assign outOfRange = oorQ;

  // R6: an out-of-range result never carries data
  a_r6_oor_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    oorQ |-> (rdDataQ == '0));

  // R8: no capture while the address-compute cycle runs
  a_r8_no_capture_busy: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capture && strobe.commit));

  // R10: a committed write leaves a zero result
  a_r10_write_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && wrQ) |=> (rdDataQ == '0));

endmodule

// File: rtl/dsu_top.sv
module dsu_top
  import dsu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int GPR_N   = 32,
  parameter int STDIO_N = 64,
  parameter int EXTIO_N = 160,
  parameter int SRAM_N  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqIndirect,
  input  logic [1:0]        ptrSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              outOfRange
);

  ctrlStrobeT strobe;

  dsu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  dsu_datapath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .GPR_N   (GPR_N),
    .STDIO_N (STDIO_N),
    .EXTIO_N (EXTIO_N),
    .SRAM_N  (SRAM_N)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqWrite    (reqWrite),
    .reqIndirect (reqIndirect),
    .ptrSel      (ptrSel),
    .reqAddr     (reqAddr),
    .wrData      (wrData),
    .rdData      (rdData),
    .outOfRange  (outOfRange)
  );

endmodule

// File: tb/dsu_top_test.sv
`timescale 1ns/1ps
module dsu_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqIndirect = 1'b0;
  logic [1:0]  ptrSel = '0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        busy, done, outOfRange;

  int checks = 0;
  int failures = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dsu_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIndirect(reqIndirect), .ptrSel(ptrSel), .reqAddr(reqAddr),
    .wrData(wrData), .rdData(rdData), .busy(busy), .done(done),
    .outOfRange(outOfRange)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] mMem [0:1279];
  logic mBusy = 1'b0, mDone = 1'b0, mOor = 1'b0, mWasWr = 1'b0;
  logic [7:0] mRd = '0;
  logic pW = 1'b0, pInd = 1'b0;
  logic [1:0] pSel = '0;
  logic [15:0] pAddr = '0;
  logic [7:0] pData = '0;

  initial for (int i = 0; i < 1280; i++) mMem[i] = 8'h00;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy <= 1'b0; mDone <= 1'b0; mRd <= '0; mOor <= 1'b0;
    end else begin
      if (mBusy) begin
        int lo, ea;
        lo = 26 + 2 * ((pSel == 2'd3) ? 2 : int'(pSel));
        ea = pInd ? (int'(mMem[lo + 1]) * 256 + int'(mMem[lo])) : int'(pAddr);
        if (ea >= 1280) begin
          mRd <= '0; mOor <= 1'b1;
        end else begin
          mOor <= 1'b0;
          mRd  <= pW ? 8'h00 : mMem[ea];
          if (pW) mMem[ea] = pData;
        end
        mWasWr <= pW;
      end
      mDone <= mBusy;
      mBusy <= reqValid && !mBusy;
      if (reqValid && !mBusy) begin
        pW <= reqWrite; pInd <= reqIndirect; pSel <= ptrSel;
        pAddr <= reqAddr; pData <= wrData;
      end
    end
  end

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      chk("R7 model busy", int'(busy), int'(mBusy));
      chk("R7 model done", int'(done), int'(mDone));
      if (mDone) begin
        chk("R6 model outOfRange", int'(outOfRange), int'(mOor));
        chk(mWasWr ? "R10 model rdData" : "R4 model rdData", int'(rdData), int'(mRd));
      end
    end
  end

  // ---------------- stimulus ----------------
  // called at a negedge; returns at the negedge of the done cycle
  task automatic issue(input bit w, input bit ind, input logic [1:0] sel,
                       input logic [15:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output logic oor);
    reqValid = 1'b1; reqWrite = w; reqIndirect = ind; ptrSel = sel;
    reqAddr = a; wrData = d;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R7 busy in first cycle", int'(busy), 1);
    chk("R7 no done in first cycle", int'(done), 0);
    @(negedge clk);
    chk("R7 done in second cycle", int'(done), 1);
    chk("R7 busy low in second cycle", int'(busy), 0);
    rd = rdData;
    oor = outOfRange;
  endtask

  task automatic wr(input int a, input int d, input string tag);
    logic [7:0] rd; logic oor;
    issue(1'b1, 1'b0, 2'd0, 16'(a), 8'(d), rd, oor);
    chk({tag, " R10 write result zero"}, int'(rd), 0);
  endtask

  task automatic rdChk(input int a, input int exp, input string tag);
    logic [7:0] rd; logic oor;
    issue(1'b0, 1'b0, 2'd0, 16'(a), 8'h00, rd, oor);
    chk(tag, int'(rd), exp);
    chk({tag, " in range"}, int'(oor), 0);
  endtask

  task automatic indRd(input logic [1:0] sel, input int exp, input int expOor, input string tag);
    logic [7:0] rd; logic oor;
    issue(1'b0, 1'b1, sel, 16'h0003, 8'h00, rd, oor);
    chk(tag, int'(rd), exp);
    chk({tag, " range flag"}, int'(oor), expOor);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] rd; logic oor;
    repeat (3) @(negedge clk);
    // R11 reset values while held in reset
    chk("R11 busy at reset", int'(busy), 0);
    chk("R11 done at reset", int'(done), 0);
    chk("R11 rdData at reset", int'(rdData), 0);
    chk("R11 outOfRange at reset", int'(outOfRange), 0);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    rdChk(5, 8'h00, "R11 register cleared");
    rdChk(40, 8'h00, "R11 std I/O cleared");
    rdChk(200, 8'h00, "R11 ext I/O cleared");

    // R1 register file
    wr(3, 8'h11, "R1"); wr(31, 8'h31, "R1");
    rdChk(3, 8'h11, "R1 reg 3"); rdChk(31, 8'h31, "R1 reg 31");
    // R2 standard I/O bank
    wr(32, 8'h20, "R2"); wr(95, 8'h5F, "R2");
    rdChk(32, 8'h20, "R2 first std"); rdChk(95, 8'h5F, "R2 last std");
    rdChk(0, 8'h00, "R2 reg 0 untouched"); rdChk(3, 8'h11, "R2 reg 3 untouched");
    // R3 extended I/O bank
    wr(96, 8'h60, "R3"); wr(255, 8'hFF, "R3");
    rdChk(96, 8'h60, "R3 first ext"); rdChk(255, 8'hFF, "R3 last ext");
    rdChk(95, 8'h5F, "R3 neighbour std untouched");
    // R4 SRAM
    wr(256, 8'hA0, "R4"); wr(1279, 8'hA1, "R4");
    rdChk(256, 8'hA0, "R4 first sram"); rdChk(1279, 8'hA1, "R4 last sram");
    rdChk(255, 8'hFF, "R4 neighbour ext untouched");

    // R5 pointer pairs
    wr(26, 8'h00, "R5"); wr(27, 8'h01, "R5");
    indRd(2'd0, 8'hA0, 0, "R5 X points at 256");
    wr(28, 8'hFF, "R5"); wr(29, 8'h04, "R5");
    indRd(2'd1, 8'hA1, 0, "R5 Y points at 1279");
    wr(30, 8'h20, "R5"); wr(31, 8'h00, "R5");
    indRd(2'd2, 8'h20, 0, "R5 Z points at 32");
    indRd(2'd3, 8'h20, 0, "R5 select 3 acts as Z");
    issue(1'b1, 1'b1, 2'd1, 16'h0000, 8'h5C, rd, oor);
    chk("R5 indirect write result", int'(rd), 0);
    rdChk(1279, 8'h5C, "R5 indirect write landed");
    rdChk(0, 8'h00, "R5 direct address ignored");

    // R9 pointer updated by the previous request is seen at once
    wr(30, 8'h5F, "R9");
    indRd(2'd2, 8'h5F, 0, "R9 fresh Z low byte");

    // R6 out of range
    issue(1'b0, 1'b0, 2'd0, 16'd1280, 8'h00, rd, oor);
    chk("R6 read 1280 data", int'(rd), 0);
    chk("R6 read 1280 flag", int'(oor), 1);
    issue(1'b1, 1'b0, 2'd0, 16'd1280, 8'h77, rd, oor);
    chk("R6 write 1280 flag", int'(oor), 1);
    rdChk(256, 8'hA0, "R6 sram start untouched");
    rdChk(0, 8'h00, "R6 reg 0 untouched");
    issue(1'b0, 1'b0, 2'd0, 16'hFFFF, 8'h00, rd, oor);
    chk("R6 read FFFF data", int'(rd), 0);
    chk("R6 read FFFF flag", int'(oor), 1);
    wr(27, 8'h05, "R6"); wr(26, 8'h00, "R6");
    indRd(2'd0, 8'h00, 1, "R6 X at 0x0500");

    // R8 request during busy is dropped
    reqValid = 1'b1; reqWrite = 1'b1; reqIndirect = 1'b0; reqAddr = 16'd300; wrData = 8'hAA;
    @(negedge clk);
    chk("R8 first request taken", int'(busy), 1);
    reqWrite = 1'b1; reqAddr = 16'd301; wrData = 8'hEE;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8 done after first", int'(done), 1);
    @(negedge clk);
    chk("R8 dropped request not started", int'(busy), 0);
    rdChk(300, 8'hAA, "R8 first write kept");
    wr(301, 8'h33, "R8");
    rdChk(301, 8'h33, "R8 location 301 holds only its own write");

    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule